// File: doc/BRIEF.md
# Isochronous Bridge Channel Status Register

This block holds the 16-bit read-only status word of one bridge channel that moves isochronous packets in both directions. It tracks whether the transmit and receive engines are running. It latches one-shot events that software inspects later: the first packet of a receive session, a change of the copy-protection field or of the odd/even field between consecutive packet headers, and eight classes of packet or timing error. It also shows the live full and empty levels of the bridge FIFO.

Control strobes, header strobes and error pulses each last one cycle. The read strobe marks the cycle in which the bus reads the word. `rd_data` is always combinational from the current state, so the value presented with `rd_stb` is the value before the read. At the following clock edge the event flags clear, unless a new event arrives in that same cycle. The header input is a plain strobe with no back-pressure. The block accepts a header on every cycle, and any header it does not use is dropped without effect.

Top module: `isoch_chan_status`

## Requirements
- R1: After reset every stored bit is 0. `rd_data` then reads 0x0008 when `fifo_empty`=1 and `fifo_full`=0.
- R2: Bit 15 (transmit busy) becomes 1 after a clock edge that samples `tx_start`=1. It becomes 0 after an edge that samples `tx_end`=1 with `tx_start`=0. If both are 1 in the same cycle, start wins.
- R3: Bit 14 (receive busy) follows `rx_start`/`rx_end` with the same rules as R2. Every `rx_start` opens a new receive session with no stored reference header.
- R4: Bit 13 is set by the first header accepted in a receive session. Later headers in that session do not set it.
- R5: Bit 12 is set when an accepted header's `hdr_emi` differs from the previous accepted header of the same session. The first header of a session only stores the reference and never sets bit 12.
- R6: Bit 11 is set when an accepted header's `hdr_oe` differs from the previous accepted header of the same session. The first header never sets it.
- R7: A header is accepted only when `hdr_vld`=1, receive busy is 1, and `rx_start`=0 in that cycle. A header that is not accepted sets no flag and does not change the stored reference.
- R8: Bit 4 equals `fifo_full` and bit 3 equals `fifo_empty` in the same cycle, with no register in between. Bit 9 always reads 0.
- R9: Error pulses are sticky, with this mapping from `err_pulse` index to bit: index 0→bit 0, 1→1, 2→2, 3→5, 4→6, 5→7, 6→8, 7→10.
- R10: `rd_stb`=1 shows the pre-read value on `rd_data`. At that edge it clears bits 13, 12, 11 and all error bits, except those being set in the same cycle, which end as 1.
- R11: A read does not change bits 15 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tx_start | input | 1 | transmit start strobe |
| tx_end | input | 1 | transmit end strobe |
| rx_start | input | 1 | receive start strobe |
| rx_end | input | 1 | receive end strobe |
| hdr_vld | input | 1 | received header strobe |
| hdr_emi | input | EMI_W | copy-protection field of the header |
| hdr_oe | input | 1 | odd/even field of the header |
| fifo_full | input | 1 | bridge FIFO full level |
| fifo_empty | input | 1 | bridge FIFO empty level |
| err_pulse | input | N_ERR | one-cycle error events |
| rd_stb | input | 1 | status read strobe |
| rd_data | output | 16 | status word |

## Verification
Nearly all state appears directly in `rd_data`. A wrong busy, event or error bit therefore shows on the port in the cycle after the edge that produced it. The reference header and the session-valid flag are hidden. A fault in either one shows only at the next accepted header, as a missing or spurious change or first-packet flag. The bench therefore sends header sequences that cross session boundaries and idle gaps, and it checks the word after every single clock edge.

// File: rtl/isoch_stat_pkg.sv
package isoch_stat_pkg;
  localparam int STAT_W  = 16;
  localparam int N_ERR   = 8;
  localparam int B_TXB   = 15;
  localparam int B_RXB   = 14;
  localparam int B_FIRST = 13;
  localparam int B_EMI   = 12;
  localparam int B_OE    = 11;
  localparam int B_FULL  = 4;
  localparam int B_EMPTY = 3;

  typedef enum int {CH_TX = 0, CH_RX = 1, CH_N = 2} chan_e;

  typedef struct packed {
    logic first;
    logic emi_chg;
    logic oe_chg;
  } evt_t;

  function automatic int err_pos(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 5;
      4: return 6;
      5: return 7;
      6: return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  // set beats clear when both hit the same bit in one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~{W{clr}}) | set;
  end
endmodule

// File: rtl/chan_busy_ctl.sv
module chan_busy_ctl #(
  parameter int N_CH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] start,
  input  logic [N_CH-1:0] stop,
  output logic [N_CH-1:0] busy
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        busy[c] <= 1'b0;
      else if (start[c]) busy[c] <= 1'b1;
      else if (stop[c])  busy[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/hdr_change_det.sv
module hdr_change_det
  import isoch_stat_pkg::*;
#(
  parameter int EMI_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sess_start,
  input  logic             rx_busy,
  input  logic             hdr_vld,
  input  logic [EMI_W-1:0] hdr_emi,
  input  logic             hdr_oe,
  input  logic             rd_clr,
  output evt_t             evt
);
  logic             have_ref;
  logic [EMI_W-1:0] ref_emi;
  logic             ref_oe;
  logic             accept;
  evt_t             evt_set;

  assign accept = hdr_vld && rx_busy && !sess_start;

  always_comb begin
    evt_set.first   = accept && !have_ref;
    evt_set.emi_chg = accept && have_ref && (hdr_emi != ref_emi);
    evt_set.oe_chg  = accept && have_ref && (hdr_oe != ref_oe);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_ref <= 1'b0;
      ref_emi  <= '0;
      ref_oe   <= 1'b0;
    end else if (sess_start) begin
      have_ref <= 1'b0;
    end else if (accept) begin
      have_ref <= 1'b1;
      ref_emi  <= hdr_emi;
      ref_oe   <= hdr_oe;
    end
  end

  sticky_bank #(.W($bits(evt_t))) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (evt_set),
    .clr   (rd_clr),
    .q     (evt)
  );
endmodule

// File: rtl/isoch_chan_status.sv
module isoch_chan_status
  import isoch_stat_pkg::*;
#(
  parameter int EMI_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              tx_end,
  input  logic              rx_start,
  input  logic              rx_end,
  input  logic              hdr_vld,
  input  logic [EMI_W-1:0]  hdr_emi,
  input  logic              hdr_oe,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic [N_ERR-1:0]  err_pulse,
  input  logic              rd_stb,
  output logic [STAT_W-1:0] rd_data
);
  logic [CH_N-1:0]  busy;
  logic [N_ERR-1:0] err_q;
  evt_t             evt;

  chan_busy_ctl #(.N_CH(CH_N)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start ({rx_start, tx_start}),
    .stop  ({rx_end, tx_end}),
    .busy  (busy)
  );

  hdr_change_det #(.EMI_W(EMI_W)) u_hdr (
    .clk        (clk),
    .rst_n      (rst_n),
    .sess_start (rx_start),
    .rx_busy    (busy[CH_RX]),
    .hdr_vld    (hdr_vld),
    .hdr_emi    (hdr_emi),
    .hdr_oe     (hdr_oe),
    .rd_clr     (rd_stb),
    .evt        (evt)
  );

  sticky_bank #(.W(N_ERR)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_pulse),
    .clr   (rd_stb),
    .q     (err_q)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[B_TXB]   = busy[CH_TX];
    rd_data[B_RXB]   = busy[CH_RX];
    rd_data[B_FIRST] = evt.first;
    rd_data[B_EMI]   = evt.emi_chg;
    rd_data[B_OE]    = evt.oe_chg;
    rd_data[B_FULL]  = fifo_full;
    rd_data[B_EMPTY] = fifo_empty;
    for (int i = 0; i < N_ERR; i++) rd_data[err_pos(i)] = err_q[i];
  end
endmodule

// File: rtl/isoch_chan_status_chk.sv
module isoch_chan_status_chk
  import isoch_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tx_start,
  input logic              tx_end,
  input logic              rx_start,
  input logic              rx_end,
  input logic              hdr_vld,
  input logic [N_ERR-1:0]  err_pulse,
  input logic              rd_stb,
  input logic [STAT_W-1:0] rd_data
);
  p_txbusy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> rd_data[B_TXB]);
  p_txbusy_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && !tx_start) |=> !rd_data[B_TXB]);
  p_rxbusy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> rd_data[B_RXB]);
  p_rxbusy_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && !rx_start) |=> !rd_data[B_RXB]);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !rd_stb) |=> rd_data[0]);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && err_pulse[0]) |=> rd_data[0]);
  p_evt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !hdr_vld) |=> !rd_data[B_FIRST] && !rd_data[B_EMI] && !rd_data[B_OE]);
  p_busy_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !tx_start && !tx_end) |=> $stable(rd_data[B_TXB]));
endmodule

bind isoch_chan_status isoch_chan_status_chk u_chk (.*);

// File: tb/isoch_chan_status_tb_top.sv
module isoch_chan_status_tb_top;
  localparam int EMI_W = 2;
  localparam int EPOS[8] = '{0, 1, 2, 5, 6, 7, 8, 10};

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_start = 0, tx_end = 0, rx_start = 0, rx_end = 0, hdr_vld = 0, hdr_oe = 0;
  logic [EMI_W-1:0] hdr_emi = '0;
  logic fifo_full = 0, fifo_empty = 1, rd_stb = 0;
  logic [7:0] err_pulse = '0;
  logic [15:0] rd_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  isoch_chan_status #(.EMI_W(EMI_W)) dut_i (.*);

  // requirement-level model
  logic m_tx = 0, m_rx = 0, m_first = 0, m_emi = 0, m_oe = 0, m_have = 0, r_oe = 0;
  logic [EMI_W-1:0] r_emi = '0;
  logic [7:0] m_err = '0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [15:0] model_word(input logic ff, input logic fe);
    logic [15:0] w = '0;
    w[15] = m_tx; w[14] = m_rx; w[13] = m_first; w[12] = m_emi; w[11] = m_oe;
    w[4] = ff; w[3] = fe;
    for (int i = 0; i < 8; i++) w[EPOS[i]] = m_err[i];
    return w;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rd_data actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic ts = 0, input logic te = 0,
                     input logic rs = 0, input logic re = 0, input logic hv = 0,
                     input logic [EMI_W-1:0] emi = '0, input logic oe = 0,
                     input logic [7:0] ep = '0, input logic rd = 0,
                     input logic ff = 0, input logic fe = 1);
    logic acc;
    @(negedge clk);
    tx_start = ts; tx_end = te; rx_start = rs; rx_end = re; hdr_vld = hv;
    hdr_emi = emi; hdr_oe = oe; err_pulse = ep; rd_stb = rd;
    fifo_full = ff; fifo_empty = fe;
    #1;
    check({req, " comb"}, rd_data, model_word(ff, fe)); // R8, R10 pre-read value
    acc = hv && m_rx && !rs;
    if (rd) begin m_first = 0; m_emi = 0; m_oe = 0; m_err = '0; end
    if (acc && !m_have) m_first = 1;
    if (acc && m_have && emi != r_emi) m_emi = 1;
    if (acc && m_have && oe != r_oe) m_oe = 1;
    m_err = m_err | ep;
    if (rs) m_have = 0;
    else if (acc) begin m_have = 1; r_emi = emi; r_oe = oe; end
    if (ts) m_tx = 1; else if (te) m_tx = 0;
    if (rs) m_rx = 1; else if (re) m_rx = 0;
    exp_q.push_back(model_word(ff, fe));
    tag_q.push_back(req);
  endtask

  // monitor: compares after each edge
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #23;
    check("R1 reset", rd_data, 16'h0008);
    rst_n = 1'b1;
    cyc("R1 idle");
    cyc("R2 tx start", .ts(1));
    cyc("R2 hold");
    cyc("R2 tx end", .te(1));
    cyc("R2 start wins", .ts(1), .te(1));
    cyc("R3 rx start", .rs(1));
    cyc("R7 hdr on start", .rs(1), .hv(1), .emi(2'd3));
    cyc("R4 first pkt", .hv(1), .emi(2'd1));
    cyc("R5 same emi", .hv(1), .emi(2'd1));
    cyc("R5 emi change", .hv(1), .emi(2'd2));
    cyc("R10 read clear", .rd(1));
    cyc("R11 busy kept");
    cyc("R6 oe change", .hv(1), .emi(2'd2), .oe(1));
    cyc("R10 set wins", .rd(1), .hv(1), .emi(2'd2), .oe(0), .ep(8'h08));
    cyc("R10 clear", .rd(1));
    for (int i = 0; i < 8; i++) cyc("R9 err map", .ep(8'(1 << i)));
    cyc("R9 hold");
    cyc("R10 err clear", .rd(1));
    cyc("R8 full", .ff(1), .fe(0));
    cyc("R8 mid", .ff(0), .fe(0));
    cyc("R3 rx end", .re(1));
    cyc("R7 ignored hdr", .hv(1), .emi(2'd0), .oe(1));
    cyc("R7 ignored read", .rd(1));
    cyc("R3 new session", .rs(1));
    cyc("R4 first again", .hv(1), .emi(2'd0), .oe(0));
    cyc("R5 no chg", .hv(1), .emi(2'd0), .oe(0));
    cyc("R3 restart busy", .rs(1));
    cyc("R5 new ref", .hv(1), .emi(2'd3), .oe(1));
    cyc("R5 final", .rd(1));
    cyc("R11 end");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule